// File: doc/BRIEF.md
# Segment Access Limit Checker

This block decides whether a data access may proceed inside a memory segment. Each request gives an offset and an access size of one, two or four bytes. It also gives the cached fields of the segment descriptor: the four-bit type code, the default-size bit, the 32-bit limit, and the valid, present and code/data flags. The request is either a read or a write.

One clock after a request strobe, the block returns a response strobe, a fault flag and one flag-update strobe. A read that passes raises the strobe that marks the descriptor as readable. A write that passes raises the strobe that marks it as writable. A failing access raises only the fault flag.

The surrounding pipeline loads the descriptor, forms the linear address and delivers the exception.

Top module: `seg_limit_chk`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, rsp_valid, rsp_fault, set_readable and set_writable are all 0.
- R2: A request sampled on req_valid at one rising edge produces rsp_valid=1 after the next rising edge. A cycle without a request produces all four outputs at 0.
- R3: Normal segments use an expand-up rule. The access faults when size−1 > limit, or when offset > limit − size + 1. All values are unsigned 32-bit and no wrap is allowed.
- R4: Expand-down segments have an upper bound of 0xFFFFFFFF when desc_big=1 and 0x0000FFFF when desc_big=0.
- R5: Expand-down segments use a different rule. The access faults when offset ≤ limit, when offset > upper bound, or when (upper bound − offset) < size − 1.
- R6: A read follows the expand-up rule for type codes 0, 1, 2, 3, 10, 11, 14 and 15. It follows the expand-down rule for codes 4 to 7. It faults for every other code.
- R7: A write follows the expand-up rule for codes 2 and 3 and the expand-down rule for codes 6 and 7. It faults for every other code.
- R8: When prot_mode=1, a request faults if desc_valid=0 or desc_present=0. A write also faults if desc_sys=0 (a system descriptor). When prot_mode=0, these three flags have no effect.
- R9: A passing read raises set_readable only. A passing write raises set_writable only. A faulting access raises rsp_fault with neither update strobe.
- R10: req_len selects the access size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. The code 3 always faults.
- R11: rsp_fault is never high without rsp_valid, and is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| prot_mode | input | 1 | Protected-mode checks enabled |
| desc_valid | input | 1 | Descriptor cache entry is valid |
| desc_present | input | 1 | Segment present flag |
| desc_sys | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| desc_type | input | 4 | Descriptor type code |
| desc_big | input | 1 | Default-size bit, selects expand-down upper bound |
| desc_limit | input | 32 | Segment limit in bytes |
| req_offset | input | 32 | Offset of the first accessed byte |
| req_len | input | 2 | Access size code |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Access faulted |
| set_readable | output | 1 | Set the descriptor's cached readable flag |
| set_writable | output | 1 | Set the descriptor's cached writable flag |

## Verification
Two things meet in one cycle: the registered response to one request, and the acceptance of the next request. The bench provokes this with long runs of back-to-back strobes, with each descriptor and offset different from the last, and with idle gaps mixed in. A behavioural model compares the outputs after every edge against the verdict for the request before, never the current one. Offsets cluster around the limit and the upper bound, so that a stale or early response would show as a wrong fault or a wrong strobe.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

    typedef enum logic [1:0] {
        RULE_NONE = 2'd0,
        RULE_UP   = 2'd1,
        RULE_DOWN = 2'd2
    } rule_e;

    typedef struct packed {
        logic rsp_valid;
        logic fault;
        logic set_rd;
        logic set_wr;
    } resp_t;

    localparam int unsigned LEN_M1_W = 3;

endpackage

// File: rtl/segchk_type_dec.sv
module segchk_type_dec
    import segchk_pkg::*;
#(
    parameter int unsigned TYPE_W = 4
) (
    input  logic [TYPE_W-1:0] kind,
    input  logic              is_write,
    output rule_e             rule
);
    // Read: codes 4..7 are expand-down; 0..3, 10, 11, 14, 15 are expand-up.
    // Write: only writable data codes 2,3 (up) and 6,7 (down).
    always_comb begin
        rule = RULE_NONE;
        if (is_write) begin
            case (kind)
                TYPE_W'(2), TYPE_W'(3): rule = RULE_UP;
                TYPE_W'(6), TYPE_W'(7): rule = RULE_DOWN;
                default:                rule = RULE_NONE;
            endcase
        end else begin
            case (kind)
                TYPE_W'(0), TYPE_W'(1), TYPE_W'(2), TYPE_W'(3),
                TYPE_W'(10), TYPE_W'(11), TYPE_W'(14), TYPE_W'(15):
                    rule = RULE_UP;
                TYPE_W'(4), TYPE_W'(5), TYPE_W'(6), TYPE_W'(7):
                    rule = RULE_DOWN;
                default:
                    rule = RULE_NONE;
            endcase
        end
    end
endmodule

// File: rtl/segchk_rule_up.sv
module segchk_rule_up
    import segchk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]   limit,
    input  logic [ADDR_W-1:0]   offset,
    input  logic [LEN_M1_W-1:0] len_m1,
    output logic                viol
);
    localparam int unsigned EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] lim_x;
    logic [EXT_W-1:0] off_x;
    logic [EXT_W-1:0] span_x;
    logic [EXT_W-1:0] last_ok;
    logic             too_long;
    logic             past_end;

    always_comb begin
        lim_x    = {1'b0, limit};
        off_x    = {1'b0, offset};
        span_x   = {{(EXT_W-LEN_M1_W){1'b0}}, len_m1};
        too_long = span_x > lim_x;
        // last start offset that still fits; only meaningful if !too_long
        last_ok  = lim_x - span_x;
        past_end = off_x > last_ok;
        viol     = too_long | past_end;
    end
endmodule

// File: rtl/segchk_rule_down.sv
module segchk_rule_down
    import segchk_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SMALL_W = 16
) (
    input  logic [ADDR_W-1:0]   limit,
    input  logic [ADDR_W-1:0]   offset,
    input  logic [LEN_M1_W-1:0] len_m1,
    input  logic                big,
    output logic                viol
);
    localparam int unsigned EXT_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] SMALL_TOP =
        {{(ADDR_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

    logic [ADDR_W-1:0] top;
    logic [EXT_W-1:0]  room;
    logic [EXT_W-1:0]  span_x;
    logic              in_hole;
    logic              over_top;
    logic              no_room;

    always_comb begin
        top      = big ? {ADDR_W{1'b1}} : SMALL_TOP;
        span_x   = {{(EXT_W-LEN_M1_W){1'b0}}, len_m1};
        in_hole  = offset <= limit;
        over_top = offset > top;
        room     = {1'b0, top} - {1'b0, offset};
        no_room  = !over_top && (room < span_x);
        viol     = in_hole | over_top | no_room;
    end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import segchk_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TYPE_W  = 4,
    parameter int unsigned SMALL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              prot_mode,
    input  logic              desc_valid,
    input  logic              desc_present,
    input  logic              desc_sys,
    input  logic [TYPE_W-1:0] desc_type,
    input  logic              desc_big,
    input  logic [ADDR_W-1:0] desc_limit,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [1:0]        req_len,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              set_readable,
    output logic              set_writable
);
    rule_e               rule;
    logic [LEN_M1_W-1:0] len_m1;
    logic                len_bad;
    logic                up_viol;
    logic                dn_viol;
    logic                pm_bad;
    logic                flt;
    resp_t               resp_d;
    resp_t               resp_q;

    segchk_type_dec #(.TYPE_W(TYPE_W)) u_type (
        .kind     (desc_type),
        .is_write (req_write),
        .rule     (rule)
    );

    segchk_rule_up #(.ADDR_W(ADDR_W)) u_up (
        .limit  (desc_limit),
        .offset (req_offset),
        .len_m1 (len_m1),
        .viol   (up_viol)
    );

    segchk_rule_down #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W)) u_down (
        .limit  (desc_limit),
        .offset (req_offset),
        .len_m1 (len_m1),
        .big    (desc_big),
        .viol   (dn_viol)
    );

    always_comb begin
        len_bad = 1'b0;
        case (req_len)
            2'd0:    len_m1 = LEN_M1_W'(0);
            2'd1:    len_m1 = LEN_M1_W'(1);
            2'd2:    len_m1 = LEN_M1_W'(3);
            default: begin
                len_m1  = LEN_M1_W'(0);
                len_bad = 1'b1;
            end
        endcase

        pm_bad = prot_mode &&
                 (!desc_valid || !desc_present || (req_write && !desc_sys));

        unique case (rule)
            RULE_UP:   flt = up_viol;
            RULE_DOWN: flt = dn_viol;
            default:   flt = 1'b1;
        endcase
        flt = flt | len_bad | pm_bad;

        resp_d = '0;
        if (req_valid) begin
            resp_d.rsp_valid = 1'b1;
            resp_d.fault     = flt;
            resp_d.set_rd    = !flt && !req_write;
            resp_d.set_wr    = !flt && req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rsp_valid    = resp_q.rsp_valid;
    assign rsp_fault    = resp_q.fault;
    assign set_readable = resp_q.set_rd;
    assign set_writable = resp_q.set_wr;
endmodule

// File: rtl/seg_limit_chk_props.sv
module seg_limit_chk_props (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       prot_mode,
    input logic       desc_present,
    input logic       wr_type_bit,
    input logic [1:0] req_len,
    input logic       rsp_valid,
    input logic       rsp_fault,
    input logic       set_readable,
    input logic       set_writable
);
    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_fault && !set_readable && !set_writable);

    p_fault_has_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_fault, set_readable, set_writable}) == 1);

    p_read_no_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !set_writable);

    p_bad_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len == 2'd3) |=> rsp_fault);

    p_wr_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !wr_type_bit) |=> rsp_fault);

    p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_mode && !desc_present) |=> rsp_fault);
endmodule

bind seg_limit_chk seg_limit_chk_props u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .prot_mode    (prot_mode),
    .desc_present (desc_present),
    .wr_type_bit  (desc_type[1]),
    .req_len      (req_len),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .set_readable (set_readable),
    .set_writable (set_writable)
);

// File: tb/seg_limit_chk_test.sv
module seg_limit_chk_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, prot_mode = 1'b0;
    logic        desc_valid = 1'b1, desc_present = 1'b1, desc_sys = 1'b1;
    logic [3:0]  desc_type = 4'd0;
    logic        desc_big = 1'b0;
    logic [31:0] desc_limit = 32'd0, req_offset = 32'd0;
    logic [1:0]  req_len = 2'd0;
    logic        rsp_valid, rsp_fault, set_readable, set_writable;

    int total = 0;
    int bad = 0;
    bit [3:0] exp_q[$];
    string    tag_q[$];

    always #5 clk = ~clk;

    seg_limit_chk uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .prot_mode(prot_mode), .desc_valid(desc_valid), .desc_present(desc_present),
        .desc_sys(desc_sys), .desc_type(desc_type), .desc_big(desc_big),
        .desc_limit(desc_limit), .req_offset(req_offset), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .set_readable(set_readable), .set_writable(set_writable)
    );

    function automatic bit model_fault(bit wr, bit pm, bit v, bit p, bit s,
                                       int ty, bit big, longint lim,
                                       longint off, int lc);
        longint n, ub;
        bit up, dn;
        if (lc == 3) return 1;
        n = (lc == 0) ? 1 : (lc == 1) ? 2 : 4;
        if (pm && (!v || !p)) return 1;
        if (pm && wr && !s) return 1;
        if (wr) begin
            up = (ty == 2 || ty == 3);
            dn = (ty == 6 || ty == 7);
        end else begin
            up = (ty <= 3 || ty == 10 || ty == 11 || ty == 14 || ty == 15);
            dn = (ty >= 4 && ty <= 7);
        end
        if (up) return (n - 1 > lim) || (off > lim - n + 1);
        if (dn) begin
            ub = big ? 64'hFFFF_FFFF : 64'hFFFF;
            return (off <= lim) || (off > ub) || (ub - off < n - 1);
        end
        return 1;
    endfunction

    task automatic check_now(string tag, bit [3:0] exp);
        bit [3:0] act = {rsp_valid, rsp_fault, set_readable, set_writable};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {valid,fault,rd,wr} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one cycle: check previous response at negedge, then drive the next request
    task automatic cycle(bit vld, bit wr, bit pm, bit v, bit p, bit s, int ty,
                         bit big, bit [31:0] lim, bit [31:0] off, int lc, string tag);
        bit f;
        @(negedge clk);
        check_now(tag_q.pop_front(), exp_q.pop_front());
        req_valid = vld; req_write = wr; prot_mode = pm;
        desc_valid = v; desc_present = p; desc_sys = s;
        desc_type = 4'(ty); desc_big = big; desc_limit = lim;
        req_offset = off; req_len = 2'(lc);
        f = model_fault(wr, pm, v, p, s, ty, big, longint'(lim), longint'(off), lc);
        exp_q.push_back(vld ? {1'b1, f, !f && !wr, !f && wr} : 4'b0000);
        tag_q.push_back(tag);
    endtask

    task automatic rd(int ty, bit big, bit [31:0] lim, bit [31:0] off, int lc, string tag);
        cycle(1, 0, 0, 1, 1, 1, ty, big, lim, off, lc, tag);
    endtask

    task automatic wr(int ty, bit big, bit [31:0] lim, bit [31:0] off, int lc, string tag);
        cycle(1, 1, 0, 1, 1, 1, ty, big, lim, off, lc, tag);
    endtask

    task automatic idle(string tag);
        cycle(0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            check_now("R1", 4'b0000);
        end
        rst_n = 1'b1;
        exp_q.push_back(4'b0000);
        tag_q.push_back("R1");

        // R2: idle gap
        idle("R2"); idle("R2");

        // R3: expand-up edges
        rd(2, 0, 32'h100, 32'hFF, 1, "R3");
        rd(2, 0, 32'h100, 32'h100, 1, "R3");
        rd(2, 0, 32'h100, 32'hFD, 2, "R3");
        rd(2, 0, 32'h100, 32'hFE, 2, "R3");
        rd(0, 0, 32'h0, 32'h0, 0, "R3");
        rd(0, 0, 32'h0, 32'h0, 1, "R3");
        rd(0, 0, 32'h2, 32'h0, 2, "R3");
        wr(3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 2, "R3");
        wr(3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 2, "R3");

        // R4: bound chosen by the size bit
        rd(6, 0, 32'h10, 32'hFFFF, 0, "R4");
        rd(6, 0, 32'h10, 32'h1_0000, 0, "R4");
        rd(6, 1, 32'h10, 32'h1_0000, 0, "R4");
        rd(6, 0, 32'h10, 32'hFFFE, 1, "R4");
        rd(6, 0, 32'h10, 32'hFFFF, 1, "R4");

        // R5: expand-down rule
        wr(7, 1, 32'h1000, 32'h1000, 0, "R5");
        wr(7, 1, 32'h1000, 32'h1001, 0, "R5");
        wr(7, 1, 32'h1000, 32'hFFFF_FFFC, 2, "R5");
        wr(7, 1, 32'h1000, 32'hFFFF_FFFD, 2, "R5");
        rd(4, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5");

        // R6 / R7: every type code, both kinds
        for (int t = 0; t < 16; t++) rd(t, 1, 32'h80, 32'h10, 0, "R6");
        for (int t = 0; t < 16; t++) rd(t, 1, 32'h8, 32'h10, 0, "R6");
        for (int t = 0; t < 16; t++) wr(t, 1, 32'h80, 32'h10, 0, "R7");
        for (int t = 0; t < 16; t++) wr(t, 1, 32'h8, 32'h10, 0, "R7");

        // R8: protected-mode flags, and their absence of effect in real mode
        cycle(1, 0, 1, 0, 1, 1, 2, 0, 32'h100, 32'h0, 0, "R8");
        cycle(1, 0, 1, 1, 0, 1, 2, 0, 32'h100, 32'h0, 0, "R8");
        cycle(1, 0, 1, 1, 1, 0, 2, 0, 32'h100, 32'h0, 0, "R8");
        cycle(1, 1, 1, 1, 1, 0, 2, 0, 32'h100, 32'h0, 0, "R8");
        cycle(1, 1, 1, 1, 1, 1, 2, 0, 32'h100, 32'h0, 0, "R8");
        cycle(1, 1, 0, 0, 0, 0, 2, 0, 32'h100, 32'h0, 0, "R8");
        cycle(1, 0, 0, 0, 0, 0, 10, 0, 32'h100, 32'h0, 0, "R8");

        // R9 / R10
        rd(2, 0, 32'h100, 32'h0, 2, "R9");
        wr(2, 0, 32'h100, 32'h0, 2, "R9");
        rd(2, 0, 32'h100, 32'h0, 3, "R10");
        wr(6, 1, 32'h0, 32'h10, 3, "R10");
        idle("R11");

        // back-to-back randomised traffic around the edges
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] lim, off, ub;
            bit big;
            int ty;
            big = 1'($urandom);
            ty  = int'($urandom_range(0, 15));
            ub  = big ? 32'hFFFF_FFFF : 32'hFFFF;
            case ($urandom_range(0, 3))
                0: lim = $urandom_range(0, 6);
                1: lim = ub - $urandom_range(0, 6);
                default: lim = $urandom;
            endcase
            case ($urandom_range(0, 3))
                0: off = lim + 32'($urandom_range(0, 8)) - 32'd4;
                1: off = ub - $urandom_range(0, 6);
                2: off = ub + $urandom_range(0, 3);
                default: off = $urandom;
            endcase
            cycle(($urandom_range(0, 5) != 0), 1'($urandom), 1'($urandom),
                  ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
                  ($urandom_range(0, 7) != 0), ty, big, lim, off,
                  int'($urandom_range(0, 3)), "R5");
        end
        idle("R2");
        @(negedge clk);
        check_now(tag_q.pop_front(), exp_q.pop_front());

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule